// File: doc/BRIEF.md
# Unaligned Word Splice Unit

This combinational datapath unit handles the four partial-word transfer operations of a little-endian 32-bit core. Two of them pull bytes from an aligned memory word into a register: one fills the register from its high end, the other from its low end. The other two push register bytes into an aligned memory word, again from the high or the low end. The byte offset of the effective address decides how many bytes move and where they land. The bytes that are not replaced keep the value of the word being merged into.

The unit sits between the address generator, the register file read port and the data memory. It always presents the effective address with its two low bits cleared. A store is a read-modify-write: the pipeline first reads the aligned word and feeds it to `mem_word`, then writes the merged word back through `merge_data` with `mem_we` high. A load feeds the aligned word the same way and takes the merged register value from `merge_data`, written only when `reg_we` is high.

Top module: `uaw_merge`

## Requirements
- R1: `mem_addr` equals `eff_addr` with bits [1:0] forced to zero, for every value of `op_sel`. The byte offset is `eff_addr[1:0]`.
- R2: With `op_sel`=2'b00 (load, high end), `merge_data` = (`reg_val` AND K) OR (`mem_word` << S). For offsets 0, 1, 2, 3, S is 24, 16, 8, 0 and K is 0x00FFFFFF, 0x0000FFFF, 0x000000FF, 0x00000000.
- R3: With `op_sel`=2'b01 (load, low end), `merge_data` = (`reg_val` AND K) OR (`mem_word` >> S). For offsets 0, 1, 2, 3, S is 0, 8, 16, 24 and K is 0x00000000, 0xFF000000, 0xFFFF0000, 0xFFFFFF00.
- R4: With `op_sel`=2'b10 (store, high end), `merge_data` = (`reg_val` >> S) OR (`mem_word` AND K). For offsets 0, 1, 2, 3, S is 24, 16, 8, 0 and K is 0xFFFFFF00, 0xFFFF0000, 0xFF000000, 0x00000000.
- R5: With `op_sel`=2'b11 (store, low end), `merge_data` = (`reg_val` << S) OR (`mem_word` AND K). For offsets 0, 1, 2, 3, S is 0, 8, 16, 24 and K is 0x00000000, 0x000000FF, 0x0000FFFF, 0x00FFFFFF.
- R6: Store selects (`op_sel[1]`=1) drive `mem_we`=1 and `reg_we`=0. Load selects drive `mem_we`=0.
- R7: On a load select, `reg_we` is 1 exactly when `dst_idx` is nonzero. Index 0 never gets a write.
- R8: All shifts are logical and fill with zeros. A byte whose top bit is set moves unchanged, with no sign extension into neighbouring bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 load high end, 01 load low end, 10 store high end, 11 store low end |
| eff_addr | input | 32 | Effective byte address |
| reg_val | input | 32 | Current value of the destination (load) or source (store) register |
| mem_word | input | 32 | Aligned memory word read at `mem_addr` |
| dst_idx | input | 5 | Destination register index for loads |
| merge_data | output | 32 | Merged register value (load) or merged memory word (store) |
| mem_addr | output | 32 | Aligned word address |
| mem_we | output | 1 | Full-word memory write enable |
| reg_we | output | 1 | Register write enable |

## Verification
The hardest cases to reach are the ones where the offset makes one operand take over completely or leaves just one byte from it. Examples are a high-end load at offset 3, which must return the memory word unchanged, and a low-end load at offset 3, which keeps three register bytes. A sweep of all sixteen operation and offset pairs reaches them. The sweep uses one register and one memory word whose bytes are all distinct, so a byte that lands in the wrong lane changes the result. Directed vectors then put bytes with the top bit set at the edges of the shift, to expose any sign fill, and drive a load with index 0.

// File: rtl/uaw_pkg.sv
package uaw_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_HI  = 2'b00,
    OP_LOAD_LO  = 2'b01,
    OP_STORE_HI = 2'b10,
    OP_STORE_LO = 2'b11
  } uaw_op_e;
endpackage

// File: rtl/uaw_ctl.sv
// Decodes the operation and byte offset into a lane count and a shift direction.
module uaw_ctl #(
  parameter int BYTES = 4,
  parameter int CNT_W = 2
) (
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] offset,
  output logic             shift_left,
  output logic [CNT_W-1:0] lanes,
  output logic             is_store
);
  localparam logic [CNT_W-1:0] TOP_LANE = CNT_W'(BYTES - 1);

  always_comb begin
    is_store   = op[1];
    // high-end load and low-end store move data toward higher lanes
    shift_left = ~(op[1] ^ op[0]);
    // high-end forms count lanes from the top, low-end forms from the bottom
    lanes      = op[0] ? offset : (TOP_LANE - offset);
  end
endmodule

// File: rtl/uaw_splice.sv
// Byte-lane splice: shifts the insert word by a lane count and keeps base bytes elsewhere.
module uaw_splice #(
  parameter int DATA_W = 32,
  parameter int BYTES  = DATA_W / 8,
  parameter int CNT_W  = 2
) (
  input  logic [DATA_W-1:0] base_word,
  input  logic [DATA_W-1:0] ins_word,
  input  logic              shift_left,
  input  logic [CNT_W-1:0]  lanes,
  output logic [DATA_W-1:0] merged
);
  logic [7:0] lane_q [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_comb begin
      int src;
      lane_q[i] = base_word[8*i +: 8];
      src = shift_left ? (i - int'(lanes)) : (i + int'(lanes));
      for (int j = 0; j < BYTES; j++) begin
        if (src == j) lane_q[i] = ins_word[8*j +: 8];
      end
    end
    assign merged[8*i +: 8] = lane_q[i];
  end
endmodule

// File: rtl/uaw_merge.sv
module uaw_merge
  import uaw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [IDX_W-1:0]  dst_idx,
  output logic [DATA_W-1:0] merge_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              reg_we
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0]  offset;
  logic              shift_left;
  logic [OFF_W-1:0]  lanes;
  logic              is_store;
  logic [DATA_W-1:0] base_word;
  logic [DATA_W-1:0] ins_word;

  assign offset   = eff_addr[OFF_W-1:0];
  assign mem_addr = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  uaw_ctl #(.BYTES(BYTES), .CNT_W(OFF_W)) u_ctl (
    .op        (op_sel),
    .offset    (offset),
    .shift_left(shift_left),
    .lanes     (lanes),
    .is_store  (is_store)
  );

  // loads splice memory into the register, stores splice the register into memory
  always_comb begin
    base_word = is_store ? mem_word : reg_val;
    ins_word  = is_store ? reg_val  : mem_word;
  end

  uaw_splice #(.DATA_W(DATA_W), .BYTES(BYTES), .CNT_W(OFF_W)) u_splice (
    .base_word (base_word),
    .ins_word  (ins_word),
    .shift_left(shift_left),
    .lanes     (lanes),
    .merged    (merge_data)
  );

  always_comb begin
    mem_we = is_store;
    reg_we = ~is_store & (dst_idx != '0);
  end

  // Immediate checks on the assembled result
  always_comb begin
    p_full_load_hi_r2: assert (!(op_sel == OP_LOAD_HI && offset == OFF_W'(BYTES-1))
                               || merge_data == mem_word)
      else $error("high-end load at top offset must return the memory word");
    p_full_load_lo_r3: assert (!(op_sel == OP_LOAD_LO && offset == '0)
                               || merge_data == mem_word)
      else $error("low-end load at offset 0 must return the memory word");
    p_full_store_hi_r4: assert (!(op_sel == OP_STORE_HI && offset == OFF_W'(BYTES-1))
                                || merge_data == reg_val)
      else $error("high-end store at top offset must write the register");
    p_full_store_lo_r5: assert (!(op_sel == OP_STORE_LO && offset == '0)
                                || merge_data == reg_val)
      else $error("low-end store at offset 0 must write the register");
    p_we_exclusive_r6: assert (!(mem_we && reg_we))
      else $error("memory and register writes asserted together");
    p_no_zero_write_r7: assert (dst_idx != '0 || !reg_we)
      else $error("write enabled for index 0");
    p_lane_kept_r8: assert (!(op_sel == OP_LOAD_LO && offset == OFF_W'(BYTES-1))
                            || merge_data[DATA_W-1:8] == reg_val[DATA_W-1:8])
      else $error("low-end load at top offset altered upper register bytes");
  end
endmodule

// File: tb/sim_uaw_merge.sv
module sim_uaw_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  op_sel;
  logic [31:0] eff_addr, reg_val, mem_word;
  logic [4:0]  dst_idx;
  logic [31:0] merge_data, mem_addr;
  logic        mem_we, reg_we;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  uaw_merge u0 (
    .op_sel(op_sel), .eff_addr(eff_addr), .reg_val(reg_val),
    .mem_word(mem_word), .dst_idx(dst_idx), .merge_data(merge_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .reg_we(reg_we)
  );

  // {op[1:0], offset[1:0], expected merge_data}, memory 0x31323334, register 0x61626364
  localparam logic [35:0] VEC [16] = '{
    {2'b00, 2'd0, 32'h34626364}, {2'b00, 2'd1, 32'h33346364},
    {2'b00, 2'd2, 32'h32333464}, {2'b00, 2'd3, 32'h31323334},
    {2'b01, 2'd0, 32'h31323334}, {2'b01, 2'd1, 32'h61313233},
    {2'b01, 2'd2, 32'h61623132}, {2'b01, 2'd3, 32'h61626331},
    {2'b10, 2'd0, 32'h31323361}, {2'b10, 2'd1, 32'h31326162},
    {2'b10, 2'd2, 32'h31616263}, {2'b10, 2'd3, 32'h61626364},
    {2'b11, 2'd0, 32'h61626364}, {2'b11, 2'd1, 32'h62636434},
    {2'b11, 2'd2, 32'h63643334}, {2'b11, 2'd3, 32'h64323334}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] r, input logic [31:0] m, input logic [4:0] idx);
    @(posedge clk);
    op_sel = op; eff_addr = a; reg_val = r; mem_word = m; dst_idx = idx;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_sel = 2'b00; eff_addr = '0; reg_val = '0; mem_word = '0; dst_idx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiescent state: zero inputs, high-end load, index 0
    check("R7 idle reg_we", {31'd0, reg_we}, 32'd0);
    check("R6 idle mem_we", {31'd0, mem_we}, 32'd0);
    check("R2 idle data", merge_data, 32'd0);

    for (int i = 0; i < 16; i++) begin
      logic [1:0]  op;
      logic [1:0]  off;
      logic [31:0] exp, a;
      {op, off, exp} = VEC[i];
      a = 32'h8040_0000 + 32'(i) * 32'h0001_0104 + {30'd0, off};
      apply(op, a, 32'h61626364, 32'h31323334, 5'd9);
      case (op)
        2'b00: check("R2 load high", merge_data, exp);
        2'b01: check("R3 load low", merge_data, exp);
        2'b10: check("R4 store high", merge_data, exp);
        default: check("R5 store low", merge_data, exp);
      endcase
      check("R1 aligned addr", mem_addr, {a[31:2], 2'b00});
      check("R6 mem_we", {31'd0, mem_we}, {31'd0, op[1]});
      check("R7 reg_we", {31'd0, reg_we}, {31'd0, ~op[1]});
    end

    // load into index 0 must not write
    apply(2'b00, 32'h0000_1001, 32'h61626364, 32'h31323334, 5'd0);
    check("R7 index0 high load", {31'd0, reg_we}, 32'd0);
    apply(2'b01, 32'h0000_1002, 32'h61626364, 32'h31323334, 5'd0);
    check("R7 index0 low load", {31'd0, reg_we}, 32'd0);
    check("R6 index0 no mem write", {31'd0, mem_we}, 32'd0);
    // store with index 0 still writes memory
    apply(2'b10, 32'h0000_1003, 32'h61626364, 32'h31323334, 5'd0);
    check("R6 store ignores index", {31'd0, mem_we}, 32'd1);
    check("R1 top bits kept", mem_addr, 32'h0000_1000);
    apply(2'b11, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd1);
    check("R1 all-ones addr", mem_addr, 32'hFFFF_FFFC);

    // no sign fill
    apply(2'b01, 32'h0000_0203, 32'h0000_0000, 32'h80FF_FFFF, 5'd3);
    check("R8 low load msb byte", merge_data, 32'h0000_0080);
    apply(2'b10, 32'h0000_0200, 32'h8000_0000, 32'h0000_0000, 5'd3);
    check("R8 high store msb byte", merge_data, 32'h0000_0080);
    apply(2'b00, 32'h0000_0200, 32'h0000_0000, 32'h0000_00FF, 5'd3);
    check("R8 high load zero fill", merge_data, 32'hFF00_0000);
    apply(2'b11, 32'h0000_0201, 32'h0000_0080, 32'hFFFF_FFFF, 5'd3);
    check("R8 low store", merge_data, 32'h0000_80FF);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule